// File: doc/BRIEF.md
# CAN Bus-Off Recovery and Sleep Controller

This block handles fault confinement and operating modes for one CAN node. It compares the transmit error count from the protocol engine against an overflow limit. When the count overflows, it takes the node off the bus. On the sampled receive stream it then counts completed runs of eleven recessive bits. After 128 such runs the node may return to the bus. A configuration input selects whether that return happens at once or waits for a software request.

The block also tracks the operating mode: initialization, normal or sleep. Sleep is entered only on request. When bus activity appears in sleep, the node either wakes by itself or raises a one-shot wakeup interrupt and waits for software, again chosen by a configuration input. Transmission is allowed only in normal mode and while the node is not in bus-off. Bit timing, frame coding, CRC and the error counter's own rules are handled elsewhere.

Top module: `can_fault_mode_ctrl`

## Requirements
- R1: When `tec_i` exceeds 255 while not in bus-off, `bus_off_o` rises at the next clock edge. A value of 255 or less never causes entry. Entry is masked in the cycle `tec_clr_o` is high. `tx_allow_o` is low while `bus_off_o` is high.
- R2: While in bus-off, each valid dominant sample (`rx_bit_i`=0) restarts the run of recessive bits. Each eleventh consecutive valid recessive sample completes one occurrence and restarts the run. Occurrences are cleared whenever the node is not in bus-off, so every entry starts from zero.
- R3: With `auto_recover_i`=1, `bus_off_o` falls one cycle after the edge that registers the 128th occurrence, and never earlier.
- R4: With `auto_recover_i`=0, `recover_req_i` has no effect before 128 occurrences are seen. After that, bus-off holds until `recover_req_i` is high, and falls at the next edge.
- R5: On leaving bus-off, `tec_clr_o` is high for exactly one cycle, in the same cycle that `bus_off_o` first reads low.
- R6: While `rst_ni` is low, `mode_o` is 0 (initialization), and `bus_off_o`, `tec_clr_o`, `wake_irq_o` and `tx_allow_o` are all 0.
- R7: Mode encoding is 0=init, 1=normal, 2=sleep. `init_req_i` high forces init at the next edge, with priority over every other request. In init with `init_req_i` low, the mode becomes normal at the next edge.
- R8: Sleep is entered only from normal mode, when `sleep_req_i` is high. In init the request is ignored.
- R9: With `auto_wake_i`=1, a valid dominant sample in sleep returns the mode to normal at the next edge. Recessive samples leave the node asleep.
- R10: With `auto_wake_i`=0, the first valid dominant sample in a sleep stay gives a one-cycle `wake_irq_o` pulse and the mode stays sleep. Later dominant samples in the same stay give no pulse. `wake_req_i` returns the mode to normal at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_recover_i | input | 1 | 1: leave bus-off automatically after the recovery sequence |
| auto_wake_i | input | 1 | 1: leave sleep automatically on bus activity |
| tec_i | input | 9 | Transmit error count |
| rx_valid_i | input | 1 | Strobe marking one sampled bus bit |
| rx_bit_i | input | 1 | Sampled bus bit, 1 = recessive |
| init_req_i | input | 1 | Request for initialization mode (level) |
| sleep_req_i | input | 1 | Request for sleep mode |
| wake_req_i | input | 1 | Software exit from sleep |
| recover_req_i | input | 1 | Software request to leave bus-off |
| mode_o | output | 2 | Current mode: 0 init, 1 normal, 2 sleep |
| bus_off_o | output | 1 | Node is in bus-off |
| tx_allow_o | output | 1 | Transmission permitted |
| tec_clr_o | output | 1 | One-cycle pulse to clear the error counter |
| wake_irq_o | output | 1 | One-cycle wakeup interrupt |

## Verification
On every cycle, the assertions check several rules. Bus-off is left only after the recovery sequence, and with software return only on a request. The clear pulse accompanies each exit. A dominant sample restarts the recessive run, and the occurrence count only steps by one or clears. Sleep is entered only on request, and wakeup pulses come only in sleep with automatic wakeup off. Only the bench's scenarios can show that recovery takes exactly 128 runs of eleven bits, including when a dominant bit breaks a run early. They also show that the count restarts on every entry, and that the first-dominant-only pulse and the exact exit cycle match the requirements under both configuration settings.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    MODE_INIT   = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_SLEEP  = 2'd2
  } mode_e;
endpackage

// File: rtl/can_fc_recov_cnt.sv
module can_fc_recov_cnt #(
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rx_valid_i,
  input  logic rx_bit_i,
  output logic done_o
);
  localparam int RUN_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam int OCC_W = $clog2(RUN_COUNT + 1);

  logic [RUN_W-1:0] run_q;
  logic [OCC_W-1:0] occ_q;

  assign done_o = (occ_q == OCC_W'(RUN_COUNT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      occ_q <= '0;
    end else if (!en_i) begin
      run_q <= '0;
      occ_q <= '0;
    end else if (rx_valid_i && !done_o) begin
      if (!rx_bit_i) begin
        run_q <= '0;
      end else if (run_q == RUN_W'(RUN_LEN - 1)) begin
        run_q <= '0;
        occ_q <= occ_q + 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  p_dominant_restarts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && rx_valid_i && !rx_bit_i |=> run_q == '0);
  p_occ_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= OCC_W'(RUN_COUNT));
  p_occ_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && $past(en_i) && occ_q != $past(occ_q) |-> occ_q == $past(occ_q) + 1'b1);
endmodule

// File: rtl/can_fc_busoff.sv
module can_fc_busoff #(
  parameter int TEC_W     = 9,
  parameter int TEC_LIMIT = 255
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TEC_W-1:0] tec_i,
  input  logic             auto_i,
  input  logic             req_i,
  input  logic             seq_done_i,
  output logic             bus_off_o,
  output logic             tec_clr_o
);
  logic bus_off_q, tec_clr_q;
  logic enter, leave;

  assign enter = !bus_off_q && !tec_clr_q && (tec_i > TEC_W'(TEC_LIMIT));
  assign leave = bus_off_q && seq_done_i && (auto_i || req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_off_q <= 1'b0;
      tec_clr_q <= 1'b0;
    end else begin
      tec_clr_q <= leave;
      if (enter)      bus_off_q <= 1'b1;
      else if (leave) bus_off_q <= 1'b0;
    end
  end

  assign bus_off_o = bus_off_q;
  assign tec_clr_o = tec_clr_q;

  p_enter_busoff_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_off_q && !tec_clr_q && tec_i > TEC_W'(TEC_LIMIT) |=> bus_off_q);
  p_exit_needs_seq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_off_q) |-> $past(seq_done_i));
  p_manual_exit_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_off_q) && !$past(auto_i) |-> $past(req_i));
  p_clr_on_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_off_q) |-> tec_clr_q);
  p_clr_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tec_clr_q |=> !tec_clr_q);
endmodule

// File: rtl/can_fc_mode.sv
module can_fc_mode
  import can_fc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  init_req_i,
  input  logic  sleep_req_i,
  input  logic  wake_req_i,
  input  logic  auto_wake_i,
  input  logic  rx_valid_i,
  input  logic  rx_bit_i,
  output mode_e mode_o,
  output logic  wake_irq_o
);
  mode_e mode_q, mode_d;
  logic  armed_q, irq_q, activity, fire;

  assign activity = rx_valid_i && !rx_bit_i;
  // interrupt only on the first activity of a manual-wake sleep stay
  assign fire = (mode_q == MODE_SLEEP) && !init_req_i && !wake_req_i
                && activity && !auto_wake_i && armed_q;

  always_comb begin
    mode_d = mode_q;
    if (init_req_i) begin
      mode_d = MODE_INIT;
    end else begin
      case (mode_q)
        MODE_INIT:   mode_d = MODE_NORMAL;
        MODE_NORMAL: if (sleep_req_i) mode_d = MODE_SLEEP;
        MODE_SLEEP:  if (wake_req_i || (activity && auto_wake_i)) mode_d = MODE_NORMAL;
        default:     mode_d = MODE_INIT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_INIT;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      irq_q  <= fire;
      if (mode_q != MODE_SLEEP && mode_d == MODE_SLEEP) armed_q <= 1'b1;
      else if (fire)                                    armed_q <= 1'b0;
    end
  end

  assign mode_o     = mode_q;
  assign wake_irq_o = irq_q;

  p_init_prio_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_req_i |=> mode_q == MODE_INIT);
  p_sleep_from_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_SLEEP && $past(mode_q) != MODE_SLEEP |-> $past(sleep_req_i) && $past(mode_q) == MODE_NORMAL);
  p_auto_wake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_SLEEP && auto_wake_i && activity && !init_req_i |=> mode_q == MODE_NORMAL);
  p_irq_in_sleep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |-> mode_q == MODE_SLEEP && !$past(auto_wake_i));
  p_irq_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |=> !wake_irq_o);
endmodule

// File: rtl/can_fault_mode_ctrl.sv
module can_fault_mode_ctrl
  import can_fc_pkg::*;
#(
  parameter int TEC_W     = 9,
  parameter int TEC_LIMIT = 255,
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_recover_i,
  input  logic             auto_wake_i,
  input  logic [TEC_W-1:0] tec_i,
  input  logic             rx_valid_i,
  input  logic             rx_bit_i,
  input  logic             init_req_i,
  input  logic             sleep_req_i,
  input  logic             wake_req_i,
  input  logic             recover_req_i,
  output logic [1:0]       mode_o,
  output logic             bus_off_o,
  output logic             tx_allow_o,
  output logic             tec_clr_o,
  output logic             wake_irq_o
);
  mode_e mode;
  logic  bus_off, seq_done;

  can_fc_recov_cnt #(.RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)) u_recov (
    .clk_i, .rst_ni,
    .en_i      (bus_off),
    .rx_valid_i,
    .rx_bit_i,
    .done_o    (seq_done)
  );

  can_fc_busoff #(.TEC_W(TEC_W), .TEC_LIMIT(TEC_LIMIT)) u_busoff (
    .clk_i, .rst_ni,
    .tec_i,
    .auto_i     (auto_recover_i),
    .req_i      (recover_req_i),
    .seq_done_i (seq_done),
    .bus_off_o  (bus_off),
    .tec_clr_o
  );

  can_fc_mode u_mode (
    .clk_i, .rst_ni,
    .init_req_i, .sleep_req_i, .wake_req_i, .auto_wake_i,
    .rx_valid_i, .rx_bit_i,
    .mode_o     (mode),
    .wake_irq_o
  );

  assign mode_o     = mode;
  assign bus_off_o  = bus_off;
  assign tx_allow_o = (mode == MODE_NORMAL) && !bus_off;

  p_no_tx_busoff_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_off_o |-> !tx_allow_o);
endmodule

// File: tb/can_fault_mode_ctrl_bench.sv
`timescale 1ns/1ps
module can_fault_mode_ctrl_bench;
  localparam int SEQ_BITS = 128 * 11;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic auto_recover = 1'b0, auto_wake = 1'b0;
  logic [8:0] tec = '0;
  logic rx_valid = 1'b0, rx_bit = 1'b1;
  logic init_req = 1'b0, sleep_req = 1'b0, wake_req = 1'b0, recover_req = 1'b0;
  logic [1:0] mode;
  logic bus_off, tx_allow, tec_clr, wake_irq;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  can_fault_mode_ctrl u_can_fault_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .auto_recover_i(auto_recover), .auto_wake_i(auto_wake),
    .tec_i(tec), .rx_valid_i(rx_valid), .rx_bit_i(rx_bit),
    .init_req_i(init_req), .sleep_req_i(sleep_req), .wake_req_i(wake_req),
    .recover_req_i(recover_req),
    .mode_o(mode), .bus_off_o(bus_off), .tx_allow_o(tx_allow),
    .tec_clr_o(tec_clr), .wake_irq_o(wake_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input int n, input logic b);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1;
      rx_bit   = b;
      @(negedge clk);
    end
    rx_valid = 1'b0;
    rx_bit   = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(2);
    // R6 reset state
    chk("R6 mode", mode, 0);
    chk("R6 bus_off", bus_off, 0);
    chk("R6 tec_clr", tec_clr, 0);
    chk("R6 wake_irq", wake_irq, 0);
    chk("R6 tx_allow", tx_allow, 0);
    rst_ni = 1'b1;
    step();
    chk("R7 init to normal", mode, 1);
    chk("R7 tx_allow normal", tx_allow, 1);

    // R8 sleep on request; R10 manual wake
    sleep_req = 1'b1; step(); sleep_req = 1'b0;
    chk("R8 sleep entered", mode, 2);
    send(1, 1'b1);
    chk("R10 recessive no irq", wake_irq, 0);
    send(1, 1'b0);
    chk("R10 first dominant irq", wake_irq, 1);
    chk("R10 stays asleep", mode, 2);
    send(2, 1'b0);
    chk("R10 no second irq", wake_irq, 0);
    chk("R10 still asleep", mode, 2);
    wake_req = 1'b1; step(); wake_req = 1'b0;
    chk("R10 wake request", mode, 1);

    // R9 automatic wake
    auto_wake = 1'b1;
    sleep_req = 1'b1; step(); sleep_req = 1'b0;
    chk("R9 sleep entered", mode, 2);
    send(3, 1'b1);
    chk("R9 recessive keeps sleep", mode, 2);
    send(1, 1'b0);
    chk("R9 dominant wakes", mode, 1);
    chk("R9 no irq on auto wake", wake_irq, 0);

    // R7 init priority; R8 sleep ignored in init
    init_req = 1'b1; sleep_req = 1'b1; step();
    chk("R7 init priority", mode, 0);
    init_req = 1'b0; step();
    chk("R7 init released", mode, 1);
    init_req = 1'b1; step(); init_req = 1'b0; sleep_req = 1'b1; step(); sleep_req = 1'b0;
    chk("R8 sleep ignored from init", mode, 1);
    step();
    chk("R8 normal held", mode, 1);

    // R1 boundary
    tec = 9'd255; step();
    chk("R1 255 no entry", bus_off, 0);
    tec = 9'd0;

    // R1..R5 sweep over recovery option and early-break position
    for (int am = 0; am < 2; am++) begin
      for (int p = 0; p < 11; p++) begin
        auto_recover = logic'(am);
        tec = 9'd256; step(); tec = 9'd40;
        chk($sformatf("R1 enter am=%0d p=%0d", am, p), bus_off, 1);
        chk("R1 tx blocked", tx_allow, 0);
        if (am == 0) recover_req = 1'b1;
        send(p, 1'b1);
        send(1, 1'b0);
        recover_req = 1'b0;
        if (am == 0) chk("R4 early request ignored", bus_off, 1);
        send(SEQ_BITS - 1, 1'b1);
        chk($sformatf("R2 one bit short p=%0d", p), bus_off, 1);
        send(1, 1'b1);
        if (am == 1) begin
          chk("R3 not before next edge", bus_off, 1);
          step();
          chk($sformatf("R3 auto exit p=%0d", p), bus_off, 0);
          chk("R5 clear pulse", tec_clr, 1);
        end else begin
          step(3);
          chk("R4 held without request", bus_off, 1);
          chk("R5 no clear while held", tec_clr, 0);
          recover_req = 1'b1; step(); recover_req = 1'b0;
          chk($sformatf("R4 exit on request p=%0d", p), bus_off, 0);
          chk("R5 clear pulse", tec_clr, 1);
        end
        step();
        chk("R5 pulse one cycle", tec_clr, 0);
        chk("R1 no re-entry", bus_off, 0);
        tec = 9'd0;
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule